// File: doc/BRIEF.md
# Fan PWM and Tachometer Controller

This block drives a cooling fan and measures its speed. A pulse-width modulated output runs over a period of 256 steps. Each step lasts a programmable number of system clocks. The duty value sets how many of those steps are high. Polarity inversion, an output-gating control and an open-collector drive mode shape how the pulse reaches the pin.

On the measurement side, a tachometer input is synchronised and its rising edges are counted over a fixed window. The count is then published as pulses per window. The window is built from a tick. Software programs the tick length in system clocks, and the window length in ticks is a parameter. With a 10 µs tick and 100,000 ticks, the result is pulses per second.

Software reaches the block through a small word-addressed write/read port. Reads are combinational from the address. Writes land on the clock edge while the write enable is high.

Top module: `fan_ctrl`

## Requirements
- R1: The control word at address 0x00 holds the duty in bits 23:16, invert in bit 3, gate in bit 2, open-collector in bit 1 and a spare flag in bit 0. The timing word at 0x04 holds the step divisor N in bits 14:0 and the tick length in clocks in bits 25:15. Every other bit of both words reads 0.
- R2: In each PWM period the undriven (pre-inversion) level is high for exactly duty steps out of 256. A duty of 0 gives a constant low level and a duty of 255 is high for 255 of 256 steps.
- R3: One PWM period lasts exactly 256*(N+1) system clocks.
- R4: With invert set, the pin level is the complement of the pre-inversion level.
- R5: With gate set, the pre-inversion level is held low, so the pin sits at the invert bit's value.
- R6: With open-collector clear, pwm_oe_o is always high. With it set, pwm_oe_o is high only while pwm_o is low, and it is low for the rest of the period.
- R7: New duty and divisor values take effect only at a period boundary. A period already running finishes with the old values.
- R8: Rising edges of tach_i are counted after a two-flop synchroniser. At the end of each window of WIN_TICKS ticks, the count is published in bits 15:0 at address 0x0C and the accumulator restarts from zero. The published value changes at no other time.
- R9: The pulse count saturates at its all-ones value (CNT_W bits) instead of wrapping.
- R10: While reset is held, pwm_o is 0, pwm_oe_o is 1, and all three addresses read 0.
- R11: Writes to address 0x0C have no effect on the published count.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | System clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| wr_en_i | input | 1 | Register write strobe |
| addr_i | input | 8 | Byte address of the register |
| wdata_i | input | 32 | Write data |
| rdata_o | output | 32 | Read data for addr_i |
| tach_i | input | 1 | Tachometer pulse input, asynchronous |
| pwm_o | output | 1 | PWM pin level |
| pwm_oe_o | output | 1 | PWM pin output enable |

## Verification
A step or prescaler counter that drifts shows up within a single period. It changes the count of high cycles or of rising edges over a window of whole periods. A corrupt active duty register shows the same way, after at most one period boundary. Loading duty or divisor early is caught inside the period in which the write lands: that pulse comes out with the new width rather than the old one. On the tachometer side, a wrong window length, a missed synchroniser edge or a wrapping accumulator changes the value published at the next window end, so the fault is visible within two windows.

// File: rtl/fan_pkg.sv
package fan_pkg;
  localparam int DUTY_W = 8;
  localparam int DIV_W  = 15;
  localparam int TICK_W = 11;

  localparam logic [7:0] ADDR_CTRL = 8'h00;
  localparam logic [7:0] ADDR_TIME = 8'h04;
  localparam logic [7:0] ADDR_CNT  = 8'h0C;

  typedef struct packed {
    logic [DUTY_W-1:0] duty;
    logic              inv;
    logic              gate;
    logic              oc;
    logic              spare;
  } ctrl_t;

  typedef struct packed {
    logic [TICK_W-1:0] tick_len;
    logic [DIV_W-1:0]  div;
  } time_t;
endpackage

// File: rtl/fan_regs.sv
module fan_regs
  import fan_pkg::*;
#(
  parameter int CNT_W = 16
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             wr_en_i,
  input  logic [7:0]       addr_i,
  input  logic [31:0]      wdata_i,
  input  logic [CNT_W-1:0] cnt_i,
  output ctrl_t            ctrl_o,
  output time_t            time_o,
  output logic [31:0]      rdata_o
);
  logic unused_wdata;
  assign unused_wdata = ^{wdata_i[31:26], wdata_i[15:4]};

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      ctrl_o <= '0;
      time_o <= '0;
    end else if (wr_en_i) begin
      if (addr_i == ADDR_CTRL)
        ctrl_o <= '{duty: wdata_i[23:16], inv: wdata_i[3], gate: wdata_i[2],
                    oc: wdata_i[1], spare: wdata_i[0]};
      if (addr_i == ADDR_TIME)
        time_o <= '{tick_len: wdata_i[25:15], div: wdata_i[14:0]};
    end
  end

  always_comb begin
    rdata_o = '0;
    unique case (addr_i)
      ADDR_CTRL: rdata_o = {8'h0, ctrl_o.duty, 12'h0, ctrl_o.inv, ctrl_o.gate,
                            ctrl_o.oc, ctrl_o.spare};
      ADDR_TIME: rdata_o = {6'h0, time_o.tick_len, time_o.div};
      ADDR_CNT:  rdata_o = {{(32-CNT_W){1'b0}}, cnt_i};
      default:   rdata_o = '0;
    endcase
  end
endmodule

// File: rtl/fan_pwm.sv
module fan_pwm #(
  parameter int DUTY_W = 8,
  parameter int DIV_W  = 15
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic [DUTY_W-1:0] duty_i,
  input  logic [DIV_W-1:0]  div_i,
  input  logic              inv_i,
  input  logic              gate_i,
  input  logic              oc_i,
  output logic              pwm_o,
  output logic              oe_o,
  output logic [DUTY_W-1:0] duty_act_o,
  output logic              period_end_o
);
  localparam logic [DUTY_W-1:0] STEP_LAST = '1;

  logic [DIV_W-1:0]  pre_q, div_act_q;
  logic [DUTY_W-1:0] step_q;
  logic              step_done, lvl, drive;

  assign step_done    = (pre_q == div_act_q);
  assign period_end_o = step_done && (step_q == STEP_LAST);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      pre_q      <= '0;
      step_q     <= '0;
      div_act_q  <= '0;
      duty_act_o <= '0;
    end else begin
      pre_q <= step_done ? '0 : pre_q + 1'b1;
      if (step_done) step_q <= step_q + 1'b1;
      // shadow load only at the period edge
      if (period_end_o) begin
        duty_act_o <= duty_i;
        div_act_q  <= div_i;
      end
    end
  end

  assign lvl   = !gate_i && (step_q < duty_act_o);
  assign drive = lvl ^ inv_i;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      pwm_o <= 1'b0;
      oe_o  <= 1'b1;
    end else begin
      pwm_o <= drive;
      oe_o  <= oc_i ? !drive : 1'b1;
    end
  end
endmodule

// File: rtl/fan_tacho.sv
module fan_tacho #(
  parameter int CNT_W     = 16,
  parameter int TICK_W    = 11,
  parameter int WIN_TICKS = 100000
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              tach_i,
  input  logic [TICK_W-1:0] tick_len_i,
  output logic [CNT_W-1:0]  cnt_o,
  output logic              win_end_o
);
  localparam int WIN_W = $clog2(WIN_TICKS + 1);
  localparam logic [WIN_W-1:0] WIN_LAST = WIN_W'(WIN_TICKS - 1);
  localparam logic [CNT_W-1:0] CNT_MAX  = '1;

  logic [2:0]        sync_q;
  logic              rise;
  logic [TICK_W-1:0] tpre_q, tlim;
  logic              tick;
  logic [WIN_W-1:0]  win_q;
  logic [CNT_W-1:0]  acc_q, acc_nx;

  assign rise      = sync_q[1] && !sync_q[2];
  assign tlim      = (tick_len_i == '0) ? '0 : tick_len_i - 1'b1;
  assign tick      = (tpre_q >= tlim);
  assign win_end_o = tick && (win_q == WIN_LAST);
  assign acc_nx    = (rise && acc_q != CNT_MAX) ? acc_q + 1'b1 : acc_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      sync_q <= '0;
      tpre_q <= '0;
      win_q  <= '0;
      acc_q  <= '0;
      cnt_o  <= '0;
    end else begin
      sync_q <= {sync_q[1:0], tach_i};
      tpre_q <= tick ? '0 : tpre_q + 1'b1;
      if (tick) win_q <= win_end_o ? '0 : win_q + 1'b1;
      if (win_end_o) begin
        cnt_o <= acc_nx;
        acc_q <= '0;
      end else begin
        acc_q <= acc_nx;
      end
    end
  end
endmodule

// File: rtl/fan_ctrl.sv
module fan_ctrl
  import fan_pkg::*;
#(
  parameter int CNT_W     = 16,
  parameter int WIN_TICKS = 100000
) (
  input  logic        clk_i,
  input  logic        rst_ni,
  input  logic        wr_en_i,
  input  logic [7:0]  addr_i,
  input  logic [31:0] wdata_i,
  output logic [31:0] rdata_o,
  input  logic        tach_i,
  output logic        pwm_o,
  output logic        pwm_oe_o
);
  ctrl_t             ctrl;
  time_t             timing;
  logic [CNT_W-1:0]  cnt_val;
  logic [DUTY_W-1:0] duty_act;
  logic              period_end, win_end;
  logic              oc_en, gate_en, inv_en;

  assign oc_en   = ctrl.oc;
  assign gate_en = ctrl.gate;
  assign inv_en  = ctrl.inv;

  fan_regs #(.CNT_W(CNT_W)) u_regs (
    .clk_i(clk_i), .rst_ni(rst_ni), .wr_en_i(wr_en_i), .addr_i(addr_i),
    .wdata_i(wdata_i), .cnt_i(cnt_val), .ctrl_o(ctrl), .time_o(timing),
    .rdata_o(rdata_o)
  );

  fan_pwm #(.DUTY_W(DUTY_W), .DIV_W(DIV_W)) u_pwm (
    .clk_i(clk_i), .rst_ni(rst_ni), .duty_i(ctrl.duty), .div_i(timing.div),
    .inv_i(inv_en), .gate_i(gate_en), .oc_i(oc_en), .pwm_o(pwm_o),
    .oe_o(pwm_oe_o), .duty_act_o(duty_act), .period_end_o(period_end)
  );

  fan_tacho #(.CNT_W(CNT_W), .TICK_W(TICK_W), .WIN_TICKS(WIN_TICKS)) u_tacho (
    .clk_i(clk_i), .rst_ni(rst_ni), .tach_i(tach_i),
    .tick_len_i(timing.tick_len), .cnt_o(cnt_val), .win_end_o(win_end)
  );
endmodule

// File: rtl/fan_ctrl_chk.sv
module fan_ctrl_chk #(
  parameter int CNT_W  = 16,
  parameter int DUTY_W = 8
) (
  input logic              clk_i,
  input logic              rst_ni,
  input logic              pwm_o,
  input logic              pwm_oe_o,
  input logic              oc_en,
  input logic              gate_en,
  input logic              inv_en,
  input logic [DUTY_W-1:0] duty_act,
  input logic              period_end,
  input logic              win_end,
  input logic [CNT_W-1:0]  cnt_val
);
  // R6
  oc_release_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ($past(oc_en) && pwm_oe_o) |-> !pwm_o);
  // R6
  push_pull_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !$past(oc_en) |-> pwm_oe_o);
  // R5
  gate_idle_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $past(gate_en) |-> (pwm_o == $past(inv_en)));
  // R2
  zero_duty_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ($past(duty_act) == '0) |-> (pwm_o == $past(inv_en)));
  // R7
  duty_hold_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !$past(period_end) |-> $stable(duty_act));
  // R8
  cnt_hold_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !$past(win_end) |-> $stable(cnt_val));
endmodule

bind fan_ctrl fan_ctrl_chk #(.CNT_W(CNT_W), .DUTY_W(fan_pkg::DUTY_W)) u_chk (
  .clk_i(clk_i), .rst_ni(rst_ni), .pwm_o(pwm_o), .pwm_oe_o(pwm_oe_o),
  .oc_en(oc_en), .gate_en(gate_en), .inv_en(inv_en), .duty_act(duty_act),
  .period_end(period_end), .win_end(win_end), .cnt_val(cnt_val)
);

// File: tb/fan_ctrl_bench.sv
`timescale 1ns/1ps
module fan_ctrl_bench;
  logic        clk = 1'b0;
  logic        rst_ni, wr_en, tach, pwm, oe;
  logic [7:0]  addr;
  logic [31:0] wdata, rdata;
  int total = 0, bad = 0;
  bit done = 1'b0;

  always #2.5 clk = ~clk;

  fan_ctrl #(.CNT_W(5), .WIN_TICKS(25)) u_fan_ctrl (
    .clk_i(clk), .rst_ni(rst_ni), .wr_en_i(wr_en), .addr_i(addr),
    .wdata_i(wdata), .rdata_o(rdata), .tach_i(tach), .pwm_o(pwm),
    .pwm_oe_o(oe)
  );

  typedef struct packed {
    logic [7:0]  duty;
    logic [14:0] div;
    logic        inv;
    logic        gate;
  } vec_t;

  localparam vec_t VECS [8] = '{
    '{8'd0,   15'd0, 1'b0, 1'b0},
    '{8'd255, 15'd0, 1'b0, 1'b0},
    '{8'd64,  15'd1, 1'b0, 1'b0},
    '{8'd1,   15'd3, 1'b0, 1'b0},
    '{8'd100, 15'd2, 1'b1, 1'b0},
    '{8'd200, 15'd0, 1'b0, 1'b1},
    '{8'd200, 15'd1, 1'b1, 1'b1},
    '{8'd128, 15'd0, 1'b1, 1'b0}
  };

  task automatic check(string req, longint act, longint exp);
    total++;
    if (act != exp) begin
      bad++;
      $display("FAIL %s act=%0d exp=%0d", req, act, exp);
    end
  endtask

  task automatic wr(logic [7:0] a, logic [31:0] d);
    wr_en = 1'b1; addr = a; wdata = d;
    @(negedge clk);
    wr_en = 1'b0; addr = 8'h0C;
  endtask

  task automatic rd(logic [7:0] a, output logic [31:0] d);
    addr = a;
    #0.5;
    d = rdata;
  endtask

  task automatic pulses(int n, int half);
    for (int i = 0; i < n; i++) begin
      tach = 1'b1; repeat (half) @(negedge clk);
      tach = 1'b0; repeat (half) @(negedge clk);
    end
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    if (!done) begin
      total++; bad++;
      $display("FAIL watchdog expired");
      $display("  test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

  initial begin
    logic [31:0] d;
    int hi, ed, oen, clash, prev, per, lvl, exp_hi, k;
    rst_ni = 1'b0; wr_en = 1'b0; addr = 8'h00; wdata = '0; tach = 1'b0;
    repeat (3) @(negedge clk);
    // R10 reset state
    check("R10 pwm", pwm, 0);
    check("R10 oe", oe, 1);
    rd(8'h00, d); check("R10 ctrl", d, 0);
    rd(8'h04, d); check("R10 time", d, 0);
    rd(8'h0C, d); check("R10 cnt", d, 0);
    @(negedge clk); rst_ni = 1'b1; @(negedge clk);

    // R1 field layout
    wr(8'h00, 32'hFFFF_FFFF); rd(8'h00, d); check("R1 ctrl", d, 32'h00FF_000F);
    wr(8'h04, 32'hFFFF_FFFF); rd(8'h04, d); check("R1 time", d, 32'h03FF_FFFF);
    wr(8'h00, 32'h0); wr(8'h04, 32'h0);

    // table: R2 R3 R4 R5
    for (int i = 0; i < 8; i++) begin
      wr(8'h00, {8'h0, VECS[i].duty, 12'h0, VECS[i].inv, VECS[i].gate, 2'b00});
      wr(8'h04, {6'h0, 11'd4, VECS[i].div});
      per = 256 * (int'(VECS[i].div) + 1);
      repeat (2048 + per) @(negedge clk);
      hi = 0; ed = 0; prev = pwm;
      repeat (4 * per) begin
        @(negedge clk);
        if (pwm) hi++;
        if (pwm && prev == 0) ed++;
        prev = pwm;
      end
      lvl    = VECS[i].gate ? 0 : int'(VECS[i].duty) * (int'(VECS[i].div) + 1);
      exp_hi = VECS[i].inv ? per - lvl : lvl;
      check("R2/R4/R5 high cycles", hi, 4 * exp_hi);
      check("R3 periods", ed, (exp_hi == 0 || exp_hi == per) ? 0 : 4);
    end

    // R6 open collector
    wr(8'h04, {6'h0, 11'd4, 15'd0});
    wr(8'h00, {8'h0, 8'd64, 12'h0, 4'b0010});
    repeat (1024) @(negedge clk);
    oen = 0; clash = 0;
    repeat (256) begin
      @(negedge clk);
      if (oe) oen++;
      if (oe && pwm) clash++;
    end
    check("R6 oe cycles", oen, 192);
    check("R6 driven high", clash, 0);

    // R7 deferred duty update
    wr(8'h00, {8'h0, 8'd128, 12'h0, 4'b0000});
    repeat (1024) @(negedge clk);
    prev = pwm;
    forever begin
      @(negedge clk);
      if (pwm && prev == 0) break;
      prev = pwm;
    end
    hi = 1;
    for (int i = 1; i < 256; i++) begin
      @(negedge clk);
      if (pwm) hi++;
      if (i == 10) begin
        wr_en = 1'b1; addr = 8'h00; wdata = {8'h0, 8'd200, 16'h0};
      end
      if (i == 11) begin wr_en = 1'b0; addr = 8'h0C; end
    end
    check("R7 old duty kept", hi, 128);
    hi = 0;
    repeat (256) begin @(negedge clk); if (pwm) hi++; end
    check("R7 new duty", hi, 200);

    // tachometer: window = 25 ticks * 4 clocks
    wr(8'h00, 32'h0);
    addr = 8'h0C;
    k = 0;
    do begin
      @(negedge clk); k++;
      if (k % 2 == 0) tach = ~tach;
      #0.5;
    end while (rdata != 32'd25);
    tach = 1'b0;
    prev = int'(rdata);
    do begin @(negedge clk); #0.5; end while (int'(rdata) == prev);
    // now at the sample just after a window end (s0)
    repeat (10) @(negedge clk);
    pulses(7, 2);                          // to s38
    repeat (92) @(negedge clk);            // s130
    rd(8'h0C, d); check("R8 count", d, 7);
    repeat (75) @(negedge clk);            // s205
    rd(8'h0C, d); check("R8 cleared", d, 0);
    pulses(40, 1);                         // s285
    repeat (45) @(negedge clk);            // s330
    rd(8'h0C, d); check("R9 saturate", d, 31);
    wr(8'h0C, 32'h0000_1234);
    rd(8'h0C, d); check("R11 write ignored", d, 31);

    done = 1'b1;
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule